// File: doc/BRIEF.md
# Failsafe Watchdog and Reset Supervisor

This block watches a processor's software heartbeat and the supply level, and drives three active-low outputs: a timeout warning, a system reset and a save/alarm line. Two clean digital flags report the supply. One says the supply has risen above the start level. The other says it has dropped below the low reset level. The heartbeat is a clear input that arrives asynchronously and acts on its falling edge.

At power-up the reset stays asserted for one timeout period and then releases. After that, software must pulse the clear input within each timeout period. If the period passes with no clear, the warning line becomes a square wave of twice the timeout period, starting low. If the first low half-period also passes with no clear, reset asserts and stays asserted until a clear arrives. A supply drop below the low level overrides everything. It forces reset and save low and holds the warning high. The block then stays locked until the supply has been seen below the start level and has risen above it again.

The timeout is a parameter in clock cycles. The default of 10000 gives 10 ms at a 1 MHz clock.

Top module: `wdg_supervisor`

## Requirements
- R1: The clear input passes through two synchroniser flops followed by an edge register. A falling edge that is set up before clock edge k takes effect at edge k+2.
- R2: In the normal running state, a clear restarts the timeout count and keeps the warning output high. The warning then falls TIMEOUT_CYC cycles after the edge at which the clear took effect.
- R3: If TIMEOUT_CYC cycles pass in the running state with no clear, the warning output goes low. It then toggles every TIMEOUT_CYC cycles, and its first half-period is low.
- R4: If the first low half-period of the warning ends with no clear, reset goes low at that edge. It stays low while the warning keeps toggling, until a clear takes effect.
- R5: A clear that takes effect while the warning is toggling, or while reset is asserted, returns both outputs high. It restarts the count from zero in the running state.
- R6: A power-up sequence starts in the locked state once the supply has been seen below the start level. When the start flag is high and the low flag is low, reset is held low and save goes high for exactly TIMEOUT_CYC cycles. Reset is then released.
- R7: Clears are ignored during the power-up delay. The delay ends exactly TIMEOUT_CYC cycles after it began.
- R8: A high low-supply flag at a clock edge puts the block in the locked state at that edge, whatever the timer state. In this state reset is 0, save is 0 and warning is 1.
- R9: In the locked state clears have no effect. The state persists, even with the start flag high, until the start flag has been low and then high again while the low flag is low.
- R10: With the clear input held at a constant level, the warning output is a continuous square wave of period 2*TIMEOUT_CYC.
- R11: When a clear takes effect in the same cycle that the count reaches its terminal value, the clear wins. The warning stays high and the count restarts.
- R12: A low rst_n at a clock edge puts the block in the locked state with the fresh-power-up condition unmet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n_async | input | 1 | Watchdog clear, asynchronous, acts on falling edge |
| sup_ok | input | 1 | Supply above start level, synchronous flag |
| sup_low | input | 1 | Supply below low reset level, synchronous flag |
| warn_n | output | 1 | Timeout warning, active low |
| sys_rst_n | output | 1 | System reset, active low |
| save_n | output | 1 | Save/alarm, active low |

## Verification
The embedded assertions check on every cycle that the low-supply flag forces the locked outputs, and that a clear always wins over a terminal count. They also check that the count stays in range and steps by one, that the power-up delay cannot be cut short by a clear, and that the edge pulse lasts a single cycle. Only the bench scenarios can show the exact cycle positions. These are the power-up release after TIMEOUT_CYC cycles, the warning square wave and its period, reset escalation at the end of the first low half-period, the synchroniser latency, and the need for a fresh power-up after a brown-out.

// File: rtl/wdg_pkg.sv
// Package: shared state encoding for the watchdog supervisor.
// Assumes: nothing beyond SystemVerilog-2017 enums.
package wdg_pkg;

    // Controller states: locked, power-up delay, running, warning low/high half
    typedef enum logic [2:0] {
        ST_LOCK = 3'd0,
        ST_POR  = 3'd1,
        ST_RUN  = 3'd2,
        ST_WLO  = 3'd3,
        ST_WHI  = 3'd4
    } wdg_state_e;

endpackage

// File: rtl/wdg_clr_sync.sv
// Module: brings the asynchronous clear into the clock domain through a
// flop chain of SYNC_STAGES and emits a one-cycle pulse on its falling edge.
// Assumes: the input idles high; the chain resets to the idle level.
module wdg_clr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_async,
    output logic fall_p
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Synchroniser chain, generated per stage
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= 1'b1;
                else        chain_q[0] <= clr_n_async;
            end
        end else begin : g_next
            // Later stages follow the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b1;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // Edge register holding the last synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    // Falling edge: high last cycle, low now
    assign fall_p = prev_q & ~chain_q[SYNC_STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |=> !fall_p); // R1

endmodule

// File: rtl/wdg_timer.sv
// Module: timeout counter. Counts 0..TIMEOUT_CYC-1, flags the terminal
// value, wraps to zero on its own and restarts from zero on request.
// Assumes: TIMEOUT_CYC >= 2.
module wdg_timer #(
    parameter int TIMEOUT_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tc
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tc = (cnt_q == LAST);

    // Count with restart priority, wrap at terminal value
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tc)      cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tc) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || tc) |=> cnt_q == '0); // R2

endmodule

// File: rtl/wdg_ctrl.sv
// Module: supervisor state machine. Sequences lockout, power-up delay,
// running, warning square wave and reset escalation; drives outputs.
// Assumes: supply flags are synchronous to clk; clr_fall is one cycle.
module wdg_ctrl
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_fall,
    input  logic tc,
    input  logic sup_ok,
    input  logic sup_low,
    output logic restart,
    output logic warn_n,
    output logic sys_rst_n,
    output logic save_n
);
    wdg_state_e state_q, state_d;
    logic       arm_q, arm_d;   // supply seen below start level since lock
    logic       esc_q, esc_d;   // reset escalated
    logic       live;

    assign live = (state_q == ST_RUN) || (state_q == ST_WLO) || (state_q == ST_WHI);

    // Counter restarts while locked, on brown-out, and on accepted clears
    assign restart = sup_low || (state_q == ST_LOCK) || (live && clr_fall);

    // Next-state logic; brown-out first, then clear, then terminal count
    always_comb begin
        state_d = state_q;
        arm_d   = arm_q;
        esc_d   = esc_q;
        if (sup_low) begin
            state_d = ST_LOCK;
            arm_d   = 1'b0;
            esc_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_LOCK: begin
                    if (!sup_ok)    arm_d   = 1'b1;
                    else if (arm_q) state_d = ST_POR;
                end
                ST_POR: begin
                    if (tc) state_d = ST_RUN;
                end
                ST_RUN, ST_WLO, ST_WHI: begin
                    if (clr_fall) begin
                        state_d = ST_RUN;
                        esc_d   = 1'b0;
                    end else if (tc) begin
                        if (state_q == ST_RUN) begin
                            state_d = ST_WLO;
                        end else if (state_q == ST_WLO) begin
                            state_d = ST_WHI;
                            esc_d   = 1'b1;
                        end else begin
                            state_d = ST_WLO;
                        end
                    end
                end
                default: begin
                    state_d = ST_LOCK;
                    arm_d   = 1'b0;
                    esc_d   = 1'b0;
                end
            endcase
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
            arm_q   <= 1'b0;
            esc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
            esc_q   <= esc_d;
        end
    end

    // Output decode from registered state
    always_comb begin
        warn_n    = (state_q != ST_WLO);
        sys_rst_n = live && !esc_q;
        save_n    = (state_q != ST_LOCK);
    end

    AST_LOCK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low |=> (!sys_rst_n && !save_n && warn_n)); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && clr_fall && !sup_low) |=> (state_q == ST_RUN && warn_n && sys_rst_n)); // R11
    AST_ESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WLO && tc && !clr_fall && !sup_low) |=> !sys_rst_n); // R4
    AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POR && !tc && !sup_low) |=> (state_q == ST_POR && !sys_rst_n)); // R7
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !arm_q) |=> state_q == ST_LOCK); // R9
    AST_SAVE_IMPLIES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !save_n |-> !sys_rst_n); // R8

endmodule

// File: rtl/wdg_supervisor.sv
// Module: top of the failsafe watchdog and reset supervisor. Wires the
// clear synchroniser, the timeout counter and the state machine.
// Assumes: TIMEOUT_CYC >= 2; supply flags already clean and synchronous.
module wdg_supervisor #(
    parameter int TIMEOUT_CYC = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_async,
    input  logic sup_ok,
    input  logic sup_low,
    output logic warn_n,
    output logic sys_rst_n,
    output logic save_n
);
    logic clr_fall;
    logic tc;
    logic restart;

    wdg_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_n_async (clr_n_async),
        .fall_p      (clr_fall)
    );

    wdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tc      (tc)
    );

    wdg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_fall  (clr_fall),
        .tc        (tc),
        .sup_ok    (sup_ok),
        .sup_low   (sup_low),
        .restart   (restart),
        .warn_n    (warn_n),
        .sys_rst_n (sys_rst_n),
        .save_n    (save_n)
    );

endmodule

// File: tb/tb_wdg_supervisor.sv
// Bench: table-driven sequence plus directed corner cases, TIMEOUT_CYC = 8.
module tb_wdg_supervisor;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic ok = 1'b0;
    logic low = 1'b0;
    logic warn_n, sys_rst_n, save_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wdg_supervisor #(.TIMEOUT_CYC(T)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_n_async (clr_n),
        .sup_ok      (ok),
        .sup_low     (low),
        .warn_n      (warn_n),
        .sys_rst_n   (sys_rst_n),
        .save_n      (save_n)
    );

    typedef struct packed {
        logic       ok;
        logic       low;
        logic       clr;
        logic [7:0] n;     // negedges to wait before checking
        logic [2:0] exp;   // {warn_n, sys_rst_n, save_n}
        logic [7:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 8'd2, 3'b100, 8'd12}, // R12 locked, arming
        '{1'b1, 1'b0, 1'b1, 8'd1, 3'b101, 8'd6},  // R6 delay begins
        '{1'b1, 1'b0, 1'b1, 8'd7, 3'b101, 8'd6},  // R6 last delay cycle
        '{1'b1, 1'b0, 1'b1, 8'd1, 3'b111, 8'd6},  // R6 released
        '{1'b1, 1'b0, 1'b1, 8'd7, 3'b111, 8'd3},  // R3 just before timeout
        '{1'b1, 1'b0, 1'b1, 8'd1, 3'b011, 8'd3},  // R3 warning low
        '{1'b1, 1'b0, 1'b1, 8'd8, 3'b101, 8'd4},  // R4 escalated
        '{1'b1, 1'b0, 1'b1, 8'd8, 3'b001, 8'd3},  // R3 toggles again
        '{1'b1, 1'b0, 1'b0, 8'd2, 3'b001, 8'd1},  // R1 not yet effective
        '{1'b1, 1'b0, 1'b0, 8'd1, 3'b111, 8'd5},  // R5 clear recovers
        '{1'b1, 1'b0, 1'b0, 8'd8, 3'b011, 8'd10}, // R10 held clear
        '{1'b1, 1'b0, 1'b1, 8'd2, 3'b011, 8'd10}, // R10 rising ignored
        '{1'b1, 1'b0, 1'b0, 8'd3, 3'b111, 8'd2},  // R2 clear in warning
        '{1'b1, 1'b0, 1'b0, 8'd7, 3'b111, 8'd2},  // R2 restarted count
        '{1'b1, 1'b1, 1'b0, 8'd1, 3'b100, 8'd8},  // R8 brown-out
        '{1'b1, 1'b0, 1'b1, 8'd3, 3'b100, 8'd9},  // R9 no fresh power-up
        '{1'b1, 1'b0, 1'b0, 8'd4, 3'b100, 8'd9},  // R9 clear ignored
        '{1'b0, 1'b0, 1'b1, 8'd2, 3'b100, 8'd9},  // R9 arming
        '{1'b1, 1'b0, 1'b0, 8'd1, 3'b101, 8'd7},  // R7 delay with clear
        '{1'b1, 1'b0, 1'b0, 8'd7, 3'b101, 8'd7},  // R7 still delayed
        '{1'b1, 1'b0, 1'b0, 8'd1, 3'b111, 8'd7}   // R7 not lengthened
    };

    task automatic chk(input int req, input logic [2:0] exp);
        checks++;
        if ({warn_n, sys_rst_n, save_n} !== exp) begin
            fails++;
            $display("FAIL R%0d: outputs %b expected %b at %0t",
                     req, {warn_n, sys_rst_n, save_n}, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        chk(12, 3'b100);  // R12 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            ok    = VEC[i].ok;
            low   = VEC[i].low;
            clr_n = VEC[i].clr;
            wait_n(int'(VEC[i].n));
            chk(int'(VEC[i].req), VEC[i].exp);
        end
        // R11: clear effective on the terminal-count edge; running entered at r
        clr_n = 1'b1;
        wait_n(5);               // now after edge r+5
        clr_n = 1'b0;            // falls before edge r+6, acts at r+8
        wait_n(3);
        chk(11, 3'b111);         // R11 clear beat the timeout
        wait_n(7);
        chk(11, 3'b111);         // R11 count restarted at r+8
        wait_n(1);
        chk(2, 3'b011);          // R2 warning at r+16
        // R12: mid-run reset, then no fresh power-up condition
        rst_n = 1'b0;
        wait_n(1);
        chk(12, 3'b100);         // R12 locked after reset
        rst_n = 1'b1;
        wait_n(3);
        chk(12, 3'b100);         // R12 still locked with ok high
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule